// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple register bus (address, write strobe, 32-bit write data, combinational read data). A 16-bit down-counter is advanced by a programmable prescaler, and the prescaler is fed by a slow reference tick enable (nominally 32768 Hz). If the counter runs out while the timer is enabled, the block raises a reset request. That request stays high until the block itself is reset.

Software writes are protected by a key. The upper half-word of every write must hold 0x1234, and only the lower half-word carries the register value. The divider and the terminal count are written first into shadow registers. They take effect only when software changes the matching two-bit group of the refresh register between the values 1 and 2. To keep the system alive, software kicks the timer by flipping the counter group of the refresh register.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the registers read back as follows. Configuration (offset 0x04) reads 0x00000F00. Load (offset 0x08) reads 0x0000FFFF. Refresh (offset 0x18) reads 0x00000015, so every group holds 1. Start (offset 0x1C) reads 0. The reset request output is low.
- R2: A write whose bits 31:16 differ from 0x1234 changes no register, and it triggers no reload.
- R3: A keyed write stores bits 15:0 in configuration and load, bits 5:0 in refresh, and bit 0 in start. Every read returns the stored value with bits 31:16 at zero.
- R4: Configuration bits 15:8 hold the divisor minus one. The divisor d ranges from 1 to 256. The prescaler then emits one count pulse every d reference ticks while the timer is enabled. With a live count N ≥ 1, the reset request rises on the N·d-th enabled tick after the reload.
- R5: Writes to configuration and load change only the shadow copies. The live divider and the live count do not change until a refresh reload.
- R6: A keyed refresh write that changes bits 3:2 from 1 to 2, or from 2 to 1, reloads the live count from the load shadow. It also restarts the prescaler phase.
- R7: A refresh write that leaves a group unchanged, or sets it to 0 or 3, reloads nothing for that group.
- R8: Start bit 0 enables counting when set. While it is clear, the reference ticks have no effect and the count holds.
- R9: Once asserted, the reset request stays high through kicks, stops and new writes, until the block is reset.
- R10: Bits 5:4 of refresh control the divider reload with the same 1↔2 rule. A counter-only toggle keeps the old divider.
- R11: Without a configuration reload, the divisor is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Reference tick enable, one cycle per reference period |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data; bits 31:16 carry the key |
| busRdata | output | 32 | Read data for busAddr |
| rstReq | output | 1 | Sticky reset request on expiry |

## Verification
The hardest case to reach is the exact cycle of expiry. It depends on the product of the live divisor and the live count, and on the prescaler phase after a reload, none of which software can read directly. The bench sets up a known live state through keyed writes and a refresh toggle, then counts reference ticks one at a time until the request rises. It compares that count with N·d over a sweep of divisors and counts, and after mid-run kicks, stops, non-toggling refresh values and shadow-only writes.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] OFS_CFG   = 8'h04;
  localparam logic [7:0] OFS_LOAD  = 8'h08;
  localparam logic [7:0] OFS_REFR  = 8'h18;
  localparam logic [7:0] OFS_START = 8'h1C;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic cntLoad;
    logic run;
  } wdkStrobe_t;

  function automatic logic groupToggles(input logic [1:0] oldV, input logic [1:0] newV);
    return (oldV == 2'd1 && newV == 2'd2) || (oldV == 2'd2 && newV == 2'd1);
  endfunction
endpackage

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter logic [15:0] KEY = 16'h1234,
  parameter int DIV_RESET = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output wdkStrobe_t        strobe,
  output logic [DIV_W-1:0]  divNext,
  output logic [CNT_W-1:0]  loadNext
);
  localparam int REFR_W = 6;
  localparam logic [15:0] CFG_RESET = 16'(DIV_RESET) << 8;

  logic [15:0] cfgReg;
  logic [CNT_W-1:0] loadReg;
  logic [REFR_W-1:0] refrReg;
  logic startReg;
  logic keyOk, wrEn;
  logic selCfg, selLoad, selRefr, selStart;
  logic [2:1] groupTog;

  assign keyOk    = busWdata[31:16] == KEY;
  assign wrEn     = busWe && keyOk;
  assign selCfg   = busAddr == ADDR_W'(OFS_CFG);
  assign selLoad  = busAddr == ADDR_W'(OFS_LOAD);
  assign selRefr  = busAddr == ADDR_W'(OFS_REFR);
  assign selStart = busAddr == ADDR_W'(OFS_START);

  // groups 2 (divider) and 1 (counter) drive reloads
  for (genvar g = 1; g <= 2; g++) begin : gTog
    assign groupTog[g] = wrEn && selRefr &&
                         groupToggles(refrReg[2*g+1:2*g], busWdata[2*g+1:2*g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= CFG_RESET;
      loadReg  <= '1;
      refrReg  <= 6'b01_01_01;
      startReg <= 1'b0;
    end else if (wrEn) begin
      if (selCfg)   cfgReg   <= busWdata[15:0];
      if (selLoad)  loadReg  <= busWdata[CNT_W-1:0];
      if (selRefr)  refrReg  <= busWdata[REFR_W-1:0];
      if (selStart) startReg <= busWdata[0];
    end
  end

  assign strobe.cfgLoad = groupTog[2];
  assign strobe.cntLoad = groupTog[1];
  assign strobe.run     = startReg;
  assign divNext        = cfgReg[8 +: DIV_W];
  assign loadNext       = loadReg;

  always_comb begin
    busRdata = '0;
    if (selCfg)   busRdata[15:0]       = cfgReg;
    if (selLoad)  busRdata[CNT_W-1:0]  = loadReg;
    if (selRefr)  busRdata[REFR_W-1:0] = refrReg;
    if (selStart) busRdata[0]          = startReg;
  end

  // R2: an unkeyed write leaves all registers alone
  a_r2_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !keyOk) |=> ($stable(cfgReg) && $stable(loadReg) &&
                           $stable(refrReg) && $stable(startReg)));
  // R7: a reload strobe only follows a group that held 1 or 2
  a_r7_from_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |-> $countones(refrReg[3:2]) == 1);
endmodule

// File: rtl/wdk_datapath.sv
module wdk_datapath
  import wdk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter int DIV_RESET = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  wdkStrobe_t       strobe,
  input  logic [DIV_W-1:0] divNext,
  input  logic [CNT_W-1:0] loadNext,
  output logic             rstReq
);
  logic [DIV_W-1:0] divLive, preCnt;
  logic [CNT_W-1:0] cnt;
  logic pulse;

  assign pulse = strobe.run && tickEn && (preCnt == divLive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLive <= DIV_W'(DIV_RESET);
      preCnt  <= '0;
      cnt     <= '1;
      rstReq  <= 1'b0;
    end else begin
      if (strobe.cfgLoad) divLive <= divNext;
      if (strobe.cfgLoad || strobe.cntLoad) begin
        preCnt <= '0;
      end else if (strobe.run && tickEn) begin
        preCnt <= pulse ? '0 : preCnt + 1'b1;
      end
      if (strobe.cntLoad) begin
        cnt <= loadNext;
      end else if (pulse) begin
        if (cnt <= CNT_W'(1)) begin
          cnt    <= '0;
          rstReq <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R9: the request never falls without reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq);
  // R8: a stopped timer holds its count unless reloaded
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.cntLoad) |=> $stable(cnt));
  // R6: a counter reload takes the shadow value
  a_r6_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |=> cnt == $past(loadNext));
  // R4: the count moves by at most one per cycle
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntLoad |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || cnt == '0));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter logic [15:0] KEY = 16'h1234,
  parameter int DIV_RESET = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rstReq
);
  wdkStrobe_t strobe;
  logic [DIV_W-1:0] divNext;
  logic [CNT_W-1:0] loadNext;

  wdk_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .KEY(KEY), .DIV_RESET(DIV_RESET))
  uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .strobe(strobe), .divNext(divNext), .loadNext(loadNext)
  );

  wdk_datapath #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET))
  uData (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .divNext(divNext), .loadNext(loadNext), .rstReq(rstReq)
  );
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rstReq;
  int total = 0, bad = 0;
  bit doneFlag = 1'b0;

  localparam logic [31:0] K = 32'h1234_0000;

  keyed_watchdog dut (.clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; tickEn = 1'b0; busWe = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  // count enabled ticks until the request rises; 0 if it does not within lim
  task automatic ticks(input int lim, output int first);
    first = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk); tickEn = 1'b1;
      @(posedge clk); #1;
      if (rstReq && first == 0) first = k;
      @(negedge clk); tickEn = 1'b0;   // one idle cycle between ticks
      if (first != 0) break;
    end
    tickEn = 1'b0;
  endtask

  task automatic setup(input int d, input int n);
    doReset();
    wr(8'h04, K | 32'((d - 1) << 8));
    wr(8'h08, K | 32'(n));
    wr(8'h18, K | 32'h2A);
    wr(8'h1C, K | 32'h1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int f;
    int dList[5] = '{1, 2, 3, 7, 16};
    int nList[4] = '{1, 2, 4, 9};

    doReset();
    // R1 reset state
    rd(8'h04, v); check("R1 cfg", v, 32'h0F00);
    rd(8'h08, v); check("R1 load", v, 32'hFFFF);
    rd(8'h18, v); check("R1 refresh", v, 32'h15);
    rd(8'h1C, v); check("R1 start", v, 32'h0);
    check("R1 rstReq", {31'b0, rstReq}, 32'h0);

    // R2 wrong key ignored
    wr(8'h04, 32'hDEAD_0102); wr(8'h08, 32'h1235_0007);
    wr(8'h18, 32'h0000_002A); wr(8'h1C, 32'hFFFF_0001);
    rd(8'h04, v); check("R2 cfg", v, 32'h0F00);
    rd(8'h08, v); check("R2 load", v, 32'hFFFF);
    rd(8'h18, v); check("R2 refresh", v, 32'h15);
    rd(8'h1C, v); check("R2 start", v, 32'h0);

    // R3 keyed readback, upper half zero
    wr(8'h04, K | 32'hAB05); rd(8'h04, v); check("R3 cfg", v, 32'hAB05);
    wr(8'h08, K | 32'h1357); rd(8'h08, v); check("R3 load", v, 32'h1357);
    wr(8'h18, K | 32'hFF3F); rd(8'h18, v); check("R3 refresh", v, 32'h3F);
    wr(8'h1C, K | 32'h0003); rd(8'h1C, v); check("R3 start", v, 32'h1);

    // R4 sweep over divisor and count
    foreach (dList[i]) foreach (nList[j]) begin
      setup(dList[i], nList[j]);
      ticks(dList[i] * nList[j] + 4, f);
      check($sformatf("R4 d=%0d n=%0d", dList[i], nList[j]), f, dList[i] * nList[j]);
    end

    // R11 default divisor 16: only counter group toggled
    doReset(); wr(8'h08, K | 32'd5); wr(8'h18, K | 32'h19); wr(8'h1C, K | 32'h1);
    ticks(100, f); check("R11 default div", f, 80);

    // R5 shadow writes without refresh do not take effect
    setup(2, 4); wr(8'h08, K | 32'd40); wr(8'h04, K | 32'h0400);
    ticks(20, f); check("R5 shadow", f, 8);

    // R6 kick reloads the count
    setup(1, 10); ticks(6, f); check("R6 pre-kick", f, 0);
    wr(8'h18, K | 32'h26); ticks(20, f); check("R6 after kick", f, 10);

    // R7 unchanged value and 0 give no reload
    setup(1, 10); ticks(6, f);
    wr(8'h18, K | 32'h2A); wr(8'h18, K | 32'h22); wr(8'h18, K | 32'h2E);
    ticks(20, f); check("R7 no reload", f, 4);

    // R8 stop holds the count
    setup(1, 5); ticks(2, f);
    wr(8'h1C, K); ticks(20, f); check("R8 stopped", f, 0);
    wr(8'h1C, K | 32'h1); ticks(20, f); check("R8 resumed", f, 3);

    // R9 sticky after kick and stop
    wr(8'h18, K | 32'h26); wr(8'h1C, K); wr(8'h08, K | 32'd100);
    check("R9 sticky", {31'b0, rstReq}, 32'h1);
    doReset(); check("R9 cleared by reset", {31'b0, rstReq}, 32'h0);

    // R10 counter-only toggle keeps old divider
    setup(2, 3); wr(8'h04, K | 32'h0300); wr(8'h18, K | 32'h26);
    ticks(20, f); check("R10 keep div", f, 6);
    setup(2, 3); wr(8'h04, K | 32'h0300); wr(8'h18, K | 32'h15);
    ticks(20, f); check("R10 cfg reload", f, 12);

    doneFlag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule